// File: doc/BRIEF.md
# Auxiliary Converter Serial Readout Port

This block is the device-side controller of a three-wire readout port for a pair of auxiliary analog-to-digital converters, each of which has two multiplexed inputs. A host pulses the active-low chip-select line to start a conversion. The block times the conversion on a divided copy of its core (sample) clock. It drives the data line high to show that the result is ready. The host then clocks the 10-bit result out, most significant bit first, using a serial clock that the host supplies.

The serial clock and the chip-select line are asynchronous to the core clock. Each passes through a two-flop synchroniser, and its edges are detected in the core domain. Conversion results come from four behavioural input buses, one for each converter input. The enable bit, the divider bit and the select bits come from a register bank, which is outside this block, as plain level inputs. The register bank resets them to: divide-by-2, converter A, second input. The port carries a bit stream and not data words, so it has no valid/ready handshake. The host paces the transfer entirely with its serial clock.

Top module: `aux_readout_port`

## Requirements
- R1: After reset, `sdo` is low, and it stays low until a conversion has been started and completed.
- R2: A conversion starts only on a falling edge of `cs_n` seen while `port_en` is 1. A `cs_n` pulse while `port_en` is 0 has no effect, and `sdo` stays low.
- R3: During a conversion `sdo` is low. It goes high on the (16·D + 3)-th rising core clock edge after `cs_n` falls. D is 2 when `cfg_div4` = 0 and 4 when `cfg_div4` = 1. The 3 is the two synchroniser stages plus the edge detector.
- R4: `cfg_conv_sel` = 0 selects converter A and 1 selects converter B. The selected converter's input bit (`cfg_in_sel_a` or `cfg_in_sel_b`) chooses its first input when 0 and its second input when 1. The selection is captured at the start of the conversion, and changes made during the conversion are ignored.
- R5: `sdo` stays high through the first rising edge of `sclk` after completion. That edge carries no data.
- R6: The result is 10-bit straight binary and is sent MSB first. Each bit is placed on `sdo` after a falling edge of `sclk` and stays stable until after the next rising edge. `sdo` changes only after an `sclk` falling edge, a conversion start or a completion.
- R7: The falling `sclk` edge that follows the tenth bit returns `sdo` to low. After that, further `sclk` edges are ignored until the next start.
- R8: A valid start in any state, including during a conversion or in the middle of a readout, drives `sdo` low and restarts the conversion from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (sample) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable bit |
| cs_n | input | 1 | Active-low chip select; a falling edge starts a conversion (asynchronous) |
| sclk | input | 1 | Host serial clock, idles low (asynchronous) |
| cfg_div4 | input | 1 | Converter clock divider: 0 = core/2, 1 = core/4 |
| cfg_conv_sel | input | 1 | Converter select: 0 = A, 1 = B |
| cfg_in_sel_a | input | 1 | Converter A input select: 0 = first, 1 = second |
| cfg_in_sel_b | input | 1 | Converter B input select: 0 = first, 1 = second |
| res_a0 | input | 10 | Behavioural result, converter A, first input |
| res_a1 | input | 10 | Behavioural result, converter A, second input |
| res_b0 | input | 10 | Behavioural result, converter B, first input |
| res_b1 | input | 10 | Behavioural result, converter B, second input |
| sdo | output | 1 | Serial data / conversion-complete flag |

## Verification
The bench runs every combination of the divider, converter and input bits against several sets of result values. Each set gives the four inputs distinct values, including all-zero, all-one and alternating patterns, so that a wrong mux choice, a reversed bit order or a stuck bit each produce a different miscompare. The bench measures the completion latency for both divider settings, which separates the two conversion lengths. Directed patterns cover the remaining rules:
- a chip-select pulse while the port is disabled;
- select bits that change during a conversion;
- extra serial clocks after the last bit;
- restarts issued both during a conversion and in the middle of a readout.

// File: rtl/aux_rd_pkg.sv
package aux_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_READY = 2'd2,
    ST_SHIFT = 2'd3
  } rd_state_t;

  localparam int unsigned RES_W_DEF     = 10;
  localparam int unsigned CONV_CLKS_DEF = 16;
endpackage

// File: rtl/aux_rd_edge_sync.sv
// Multi-stage synchroniser followed by a single-edge detector.
module aux_rd_edge_sync #(
  parameter logic        IDLE_LVL    = 1'b0,
  parameter int unsigned STAGES      = 2,
  parameter logic        DETECT_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_seen
);
  logic [STAGES:0] chain;
  logic            cur_lvl;
  logic            old_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){IDLE_LVL}};
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign cur_lvl = chain[STAGES-1];
  assign old_lvl = chain[STAGES];

  generate
    if (DETECT_RISE) begin : g_rise
      assign edge_seen = cur_lvl & ~old_lvl;
    end else begin : g_fall
      assign edge_seen = ~cur_lvl & old_lvl;
    end
  endgenerate
endmodule

// File: rtl/aux_rd_conv_timer.sv
// Counts CONV_CLKS converter clocks; converter clock = core / DIV_LO or DIV_HI.
module aux_rd_conv_timer #(
  parameter int unsigned CONV_CLKS = 16,
  parameter int unsigned DIV_LO    = 2,
  parameter int unsigned DIV_HI    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic div_hi,
  output logic busy,
  output logic done
);
  localparam int unsigned PW  = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam int unsigned CCW = (CONV_CLKS > 1) ? $clog2(CONV_CLKS) : 1;
  localparam logic [PW-1:0]  PRE_LO_LAST = PW'(DIV_LO - 1);
  localparam logic [PW-1:0]  PRE_HI_LAST = PW'(DIV_HI - 1);
  localparam logic [CCW-1:0] CNT_LAST    = CCW'(CONV_CLKS - 1);

  logic [PW-1:0]  pre;
  logic [CCW-1:0] ccnt;
  logic           div_hi_q;
  logic           pre_last;
  logic           conv_tick;

  assign pre_last  = (pre == (div_hi_q ? PRE_HI_LAST : PRE_LO_LAST));
  assign conv_tick = busy & pre_last;
  assign done      = conv_tick & (ccnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pre      <= '0;
      ccnt     <= '0;
      div_hi_q <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      pre      <= '0;
      ccnt     <= '0;
      div_hi_q <= div_hi;
    end else if (busy) begin
      if (pre_last) begin
        pre  <= '0;
        ccnt <= ccnt + 1'b1;
        if (done) busy <= 1'b0;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aux_rd_result_mux.sv
// Picks one of the four converter inputs.
module aux_rd_result_mux #(
  parameter int unsigned W = 10
) (
  input  logic         conv_sel,
  input  logic         in_sel_a,
  input  logic         in_sel_b,
  input  logic [W-1:0] res_a0,
  input  logic [W-1:0] res_a1,
  input  logic [W-1:0] res_b0,
  input  logic [W-1:0] res_b1,
  output logic [W-1:0] res
);
  logic [W-1:0] tbl [4];
  logic [1:0]   idx;

  assign tbl[0] = res_a0;
  assign tbl[1] = res_a1;
  assign tbl[2] = res_b0;
  assign tbl[3] = res_b1;
  assign idx    = {conv_sel, conv_sel ? in_sel_b : in_sel_a};
  assign res    = tbl[idx];
endmodule

// File: rtl/aux_rd_shift_out.sv
// Completion flag, dummy edge, then MSB-first shift on serial clock falls.
module aux_rd_shift_out import aux_rd_pkg::*; #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         done,
  input  logic [W-1:0] res,
  input  logic         sclk_rise,
  input  logic         sclk_fall,
  output logic         sdo
);
  localparam int unsigned BCW = $clog2(W + 1);
  localparam logic [BCW-1:0] BITS_ALL = BCW'(W);

  rd_state_t      state;
  logic [W-1:0]   shreg;
  logic [BCW-1:0] bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sdo    <= 1'b0;
      shreg  <= '0;
      bitcnt <= '0;
    end else if (start) begin
      state  <= ST_CONV;
      sdo    <= 1'b0;
      bitcnt <= '0;
    end else begin
      case (state)
        ST_CONV: begin
          if (done) begin
            state <= ST_READY;
            sdo   <= 1'b1;
            shreg <= res;
          end
        end
        ST_READY: begin
          if (sclk_rise) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sclk_fall) begin
            if (bitcnt == BITS_ALL) begin
              sdo   <= 1'b0;
              state <= ST_IDLE;
            end else begin
              sdo    <= shreg[W-1];
              shreg  <= {shreg[W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/aux_readout_port.sv
module aux_readout_port import aux_rd_pkg::*; #(
  parameter int unsigned RES_W       = RES_W_DEF,
  parameter int unsigned CONV_CLKS   = CONV_CLKS_DEF,
  parameter int unsigned DIV_LO      = 2,
  parameter int unsigned DIV_HI      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             cfg_div4,
  input  logic             cfg_conv_sel,
  input  logic             cfg_in_sel_a,
  input  logic             cfg_in_sel_b,
  input  logic [RES_W-1:0] res_a0,
  input  logic [RES_W-1:0] res_a1,
  input  logic [RES_W-1:0] res_b0,
  input  logic [RES_W-1:0] res_b1,
  output logic             sdo
);
  logic             cs_fall;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             start;
  logic             tmr_busy;
  logic             tmr_done;
  logic             conv_sel_q;
  logic             in_sel_a_q;
  logic             in_sel_b_q;
  logic [RES_W-1:0] res_pick;

  aux_rd_edge_sync #(.IDLE_LVL(1'b1), .STAGES(SYNC_STAGES), .DETECT_RISE(1'b0)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n), .edge_seen(cs_fall));

  aux_rd_edge_sync #(.IDLE_LVL(1'b0), .STAGES(SYNC_STAGES), .DETECT_RISE(1'b1)) u_sclk_rise (
    .clk(clk), .rst_n(rst_n), .async_in(sclk), .edge_seen(sclk_rise));

  aux_rd_edge_sync #(.IDLE_LVL(1'b0), .STAGES(SYNC_STAGES), .DETECT_RISE(1'b0)) u_sclk_fall (
    .clk(clk), .rst_n(rst_n), .async_in(sclk), .edge_seen(sclk_fall));

  assign start = cs_fall & port_en;

  // Selection is frozen for the whole conversion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_sel_q <= 1'b0;
      in_sel_a_q <= 1'b1;
      in_sel_b_q <= 1'b1;
    end else if (start) begin
      conv_sel_q <= cfg_conv_sel;
      in_sel_a_q <= cfg_in_sel_a;
      in_sel_b_q <= cfg_in_sel_b;
    end
  end

  aux_rd_conv_timer #(.CONV_CLKS(CONV_CLKS), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .div_hi(cfg_div4),
    .busy(tmr_busy), .done(tmr_done));

  aux_rd_result_mux #(.W(RES_W)) u_mux (
    .conv_sel(conv_sel_q), .in_sel_a(in_sel_a_q), .in_sel_b(in_sel_b_q),
    .res_a0(res_a0), .res_a1(res_a1), .res_b0(res_b0), .res_b1(res_b1),
    .res(res_pick));

  aux_rd_shift_out #(.W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .done(tmr_done), .res(res_pick),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdo(sdo));
endmodule

// File: rtl/aux_readout_port_chk.sv
module aux_readout_port_chk #(
  parameter int unsigned CONV_CLKS = 16,
  parameter int unsigned DIV_LO    = 2,
  parameter int unsigned DIV_HI    = 4
) (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic cfg_div4,
  input logic sdo,
  input logic start,
  input logic tmr_busy,
  input logic tmr_done,
  input logic sclk_fall
);
  logic [15:0] cyc;
  logic        div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      div_q <= 1'b0;
    end else if (start) begin
      cyc   <= '0;
      div_q <= cfg_div4;
    end else if (tmr_busy) begin
      cyc <= cyc + 1'b1;
    end
  end

  // R3
  sdo_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !sdo);

  // R3
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |-> (int'(cyc) == int'(CONV_CLKS * (div_q ? DIV_HI : DIV_LO)) - 1));

  // R3
  done_raises_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_done && !start) |=> sdo);

  // R2
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !tmr_busy) |=> !tmr_busy);

  // R6
  sdo_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(sclk_fall) || $past(tmr_done) || $past(start)));

  // R8
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!sdo && tmr_busy));
endmodule

bind aux_readout_port aux_readout_port_chk #(
  .CONV_CLKS(CONV_CLKS), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_div4(cfg_div4), .sdo(sdo),
  .start(start), .tmr_busy(tmr_busy), .tmr_done(tmr_done), .sclk_fall(sclk_fall)
);

// File: tb/aux_readout_port_bench.sv
module aux_readout_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int W          = 10;
  localparam int CONV       = 16;

  logic clk = 1'b0;
  logic rst_n, port_en, cs_n, sclk, cfg_div4, cfg_conv_sel, cfg_in_sel_a, cfg_in_sel_b;
  logic [W-1:0] res_a0, res_a1, res_b0, res_b1;
  logic sdo;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_readout_port u_aux_readout_port (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cs_n(cs_n), .sclk(sclk),
    .cfg_div4(cfg_div4), .cfg_conv_sel(cfg_conv_sel),
    .cfg_in_sel_a(cfg_in_sel_a), .cfg_in_sel_b(cfg_in_sel_b),
    .res_a0(res_a0), .res_a1(res_a1), .res_b0(res_b0), .res_b1(res_b1),
    .sdo(sdo));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sclk_pulse(output logic hi_val);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    hi_val = sdo;
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // Falls cs_n, optionally flips the selects at cycle flip_at, returns latency.
  task automatic do_start(input int flip_at, output int lat);
    @(negedge clk);
    cs_n = 1'b0;
    lat  = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      lat++;
      if (lat == 4) cs_n = 1'b1;
      if (lat == flip_at) begin
        cfg_conv_sel = ~cfg_conv_sel;
        cfg_in_sel_a = ~cfg_in_sel_a;
        cfg_in_sel_b = ~cfg_in_sel_b;
      end
      if (sdo && lat > 3) break;
    end
    cs_n = 1'b1;
  endtask

  task automatic readout(input int exp_val);
    logic v;
    sclk_pulse(v);
    check(v == 1'b1, "R5 dummy edge", int'(v), 1);
    for (int b = W - 1; b >= 0; b--) begin
      sclk_pulse(v);
      check(v == exp_val[b], $sformatf("R6 bit%0d", b), int'(v), int'(exp_val[b]));
    end
    check(sdo == 1'b0, "R7 low after last bit", int'(sdo), 0);
  endtask

  function automatic int expected_val(input logic cs, input logic sa, input logic sb);
    if (cs) return sb ? int'(res_b1) : int'(res_b0);
    return sa ? int'(res_a1) : int'(res_a0);
  endfunction

  function automatic logic [W-1:0] pat(input int p, input int k);
    if (p == 0) begin
      case (k)
        0: return 10'h000;
        1: return 10'h3FF;
        2: return 10'h155;
        default: return 10'h2AA;
      endcase
    end
    return W'((p * 293 + k * 517 + 165) % 1024);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int   lat;
    int   exp_lat;
    int   ev;
    logic v;
    rst_n = 1'b0; port_en = 1'b0; cs_n = 1'b1; sclk = 1'b0;
    cfg_div4 = 1'b0; cfg_conv_sel = 1'b0; cfg_in_sel_a = 1'b1; cfg_in_sel_b = 1'b1;
    res_a0 = 10'h011; res_a1 = 10'h122; res_b0 = 10'h233; res_b1 = 10'h344;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sdo == 1'b0, "R1 reset state", int'(sdo), 0);

    // R2: pulse while disabled, then serial clocks; sdo must stay low.
    begin
      int highs = 0;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (sdo) highs++;
      end
      for (int i = 0; i < 3; i++) begin
        sclk_pulse(v);
        if (v) highs++;
      end
      check(highs == 0, "R2 disabled start ignored", highs, 0);
    end
    port_en = 1'b1;
    repeat (4) @(negedge clk);
    check(sdo == 1'b0, "R1 still idle after enable", int'(sdo), 0);

    // Sweep: divider x selection x value sets (R3, R4, R5, R6, R7).
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 8; s++) begin
        for (int p = 0; p < 6; p++) begin
          cfg_div4     = d[0];
          cfg_conv_sel = s[2];
          cfg_in_sel_a = s[1];
          cfg_in_sel_b = s[0];
          res_a0 = pat(p, 0); res_a1 = pat(p, 1);
          res_b0 = pat(p, 2); res_b1 = pat(p, 3);
          ev = expected_val(s[2], s[1], s[0]);
          exp_lat = CONV * (d ? 4 : 2) + 3;
          do_start(-1, lat);
          check(lat == exp_lat, "R3 completion latency", lat, exp_lat);
          readout(ev);
        end
      end
    end

    // R7: further serial clocks ignored.
    begin
      int highs = 0;
      for (int i = 0; i < 4; i++) begin
        sclk_pulse(v);
        if (v) highs++;
      end
      check(highs == 0, "R7 clocks ignored after last bit", highs, 0);
    end

    // R4: selection changed mid-conversion is ignored.
    cfg_div4 = 1'b0; cfg_conv_sel = 1'b0; cfg_in_sel_a = 1'b0; cfg_in_sel_b = 1'b0;
    res_a0 = 10'h0F0; res_a1 = 10'h30F; res_b0 = 10'h1C3; res_b1 = 10'h2B4;
    do_start(10, lat);
    check(lat == 35, "R4 latency with mid-conversion select change", lat, 35);
    readout(10'h0F0);

    // R8: restart during conversion.
    cfg_conv_sel = 1'b1; cfg_in_sel_b = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
    do_start(-1, lat);
    check(lat == 35, "R8 restart during conversion latency", lat, 35);
    readout(10'h2B4);

    // R8: restart mid-readout.
    cfg_div4 = 1'b1; cfg_conv_sel = 1'b0; cfg_in_sel_a = 1'b1;
    do_start(-1, lat);
    sclk_pulse(v);
    sclk_pulse(v);
    sclk_pulse(v);
    sclk_pulse(v);
    cfg_in_sel_a = 1'b0;
    do_start(-1, lat);
    check(lat == 67, "R8 restart mid-readout latency", lat, 67);
    readout(10'h0F0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule